// File: doc/BRIEF.md
# Variable-Frequency Phase-Shift Bridge Gate Generator

This block drives the four switches of a full bridge from two integer commands: a period count and a phase count. A single counter steps down once per clock from the period count and reloads when its cycle ends. Its position sets both the switching frequency and the instant at which the second leg turns on. Each leg is a 50% square wave with a complement output. The outputs are raw gate timing, before any dead time is added.

The leading leg turns on at the top of the count and turns off at the midpoint. The lagging leg turns on when the counter reaches the phase count. It then stays on for exactly as many clocks as the leading leg does, timed by a countdown of its own. The shift therefore runs from zero (phase count equal to period) to a full half period (phase count equal to half the period). Commands are taken only at the reload instant. Dropping the enable input forces every output low, and the next rise restarts the sequence at the top of the count.

Top module: `pshift_gate_gen`

## Requirements
- R1: While rst_n is low, or from the first clock edge that samples en low, all four outputs are low.
- R2: With en high and fixed commands, leg_a repeats every P clocks, where P is the effective period count. Its first rise is at the first clock edge that samples en high after it was low.
- R3: In each period, leg_a is high for the first P - floor(P/2) clocks and low for the rest.
- R4: leg_b rises (P - Q) clocks after the start of each period, where Q is the effective phase count. It then stays high for P - floor(P/2) clocks.
- R5: While running, leg_a_n is the inverse of leg_a and leg_b_n is the inverse of leg_b.
- R6: With Q equal to P, leg_b matches leg_a on every clock (zero shift).
- R7: With even P and Q equal to P/2, leg_b is the exact inverse of leg_a (half-period shift).
- R8: Period and phase commands are sampled only at the start of a period. A change made mid-period does not alter the remainder of that period.
- R9: A period command below 2 is treated as 2. A phase command above P is treated as P, and one below floor(P/2) is treated as floor(P/2).
- R10: With odd P and Q equal to floor(P/2), leg_b's high time runs one clock past the start of the next period and keeps its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low forces all outputs low |
| period_cmd | input | CNT_W | Switching period in clocks |
| phase_cmd | input | CNT_W | Counter value at which the lagging leg turns on |
| leg_a | output | 1 | Leading leg, high side |
| leg_a_n | output | 1 | Leading leg, low side |
| leg_b | output | 1 | Lagging leg, high side |
| leg_b_n | output | 1 | Lagging leg, low side |

## Verification
The bench builds the generator with an 8-bit counter and uses periods of 2 to 12 clocks. At these sizes every period can be checked clock by clock within a few dozen cycles. The small values also reach the clamp floor of 2, both odd and even halving, and the wrap of the lagging leg across a reload when the period is odd. A mid-period command change and an enable drop with restart are checked against a closed-form expectation of each output.

// File: rtl/pshift_gate_gen.sv
module pshift_gate_gen #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period_cmd,
  input  logic [CNT_W-1:0] phase_cmd,
  output logic             leg_a,
  output logic             leg_a_n,
  output logic             leg_b,
  output logic             leg_b_n
);

  localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic             run_q, ga_q, gb_q;
  logic [CNT_W-1:0] cnt_q, per_q, ph_q, half_q, bcnt_q;

  logic [CNT_W-1:0] per_in, half_in, ph_in;
  logic [CNT_W-1:0] per_n, ph_n, half_n, cnt_n, hi_n;
  logic             reload, trig, a_n;

  assign per_in  = (period_cmd < MIN_PER) ? MIN_PER : period_cmd;
  assign half_in = per_in >> 1;
  assign ph_in   = (phase_cmd > per_in)  ? per_in  :
                   (phase_cmd < half_in) ? half_in : phase_cmd;

  assign reload = !run_q || (cnt_q == ONE);
  assign per_n  = reload ? per_in  : per_q;
  assign ph_n   = reload ? ph_in   : ph_q;
  assign half_n = reload ? half_in : half_q;
  assign cnt_n  = reload ? per_in  : cnt_q - ONE;
  assign hi_n   = per_n - half_n;
  assign trig   = (cnt_n == ph_n);
  assign a_n    = (cnt_n > half_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      per_q  <= MIN_PER;
      ph_q   <= MIN_PER;
      half_q <= ONE;
      bcnt_q <= '0;
      ga_q   <= 1'b0;
      gb_q   <= 1'b0;
    end else if (!en) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      bcnt_q <= '0;
      ga_q   <= 1'b0;
      gb_q   <= 1'b0;
    end else begin
      run_q  <= 1'b1;
      cnt_q  <= cnt_n;
      per_q  <= per_n;
      ph_q   <= ph_n;
      half_q <= half_n;
      ga_q   <= a_n;
      if (trig) begin
        gb_q   <= 1'b1;
        bcnt_q <= hi_n - ONE;
      end else if (bcnt_q != '0) begin
        gb_q   <= 1'b1;
        bcnt_q <= bcnt_q - ONE;
      end else begin
        gb_q   <= 1'b0;
      end
    end
  end

  assign leg_a   = ga_q;
  assign leg_b   = gb_q;
  assign leg_a_n = run_q & ~ga_q;
  assign leg_b_n = run_q & ~gb_q;

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(leg_a || leg_a_n || leg_b || leg_b_n)); // R1

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q >= ONE) && (cnt_q <= per_q)); // R2

  AST_A_RISES_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(leg_a) |-> (cnt_q == per_q)); // R3

  AST_B_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && bcnt_q != '0) |-> leg_b); // R4

  AST_LEGS_OPPOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(en)) |-> (leg_a ^ leg_a_n) && (leg_b ^ leg_b_n)); // R5

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && cnt_q != per_q) |-> ($stable(per_q) && $stable(ph_q))); // R8

  AST_PHASE_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (ph_q <= per_q) && (ph_q >= half_q) && (per_q >= MIN_PER)); // R9

endmodule

// File: tb/pshift_gate_gen_test.sv
module pshift_gate_gen_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [W-1:0] period_cmd = '0;
  logic [W-1:0] phase_cmd = '0;
  logic leg_a, leg_a_n, leg_b, leg_b_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pshift_gate_gen #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .period_cmd(period_cmd), .phase_cmd(phase_cmd),
    .leg_a(leg_a), .leg_a_n(leg_a_n), .leg_b(leg_b), .leg_b_n(leg_b_n)
  );

  task automatic check(input string tag, input int k, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, k, act, exp);
    end
  endtask

  function automatic bit exp_a(int k, int p);
    return (k % p) < (p - p / 2);
  endfunction

  function automatic bit exp_b(int k, int p, int q);
    int d = k - (p - q);
    return (d >= 0) && ((d % p) < (p - p / 2));
  endfunction

  task automatic stop_run();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_pattern(input int pc, input int qc, input int n, input string tag);
    int p = (pc < 2) ? 2 : pc;
    int q = (qc > p) ? p : ((qc < p / 2) ? p / 2 : qc);
    stop_run();
    period_cmd = W'(pc);
    phase_cmd = W'(qc);
    en = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check({tag, " R2/R3 leg_a"}, k, leg_a, exp_a(k, p));
      check({tag, " R4 leg_b"}, k, leg_b, exp_b(k, p, q));
      check({tag, " R5 complements"}, k, leg_a_n ^ leg_b_n, leg_a ^ leg_b);
      check({tag, " R5 leg_a_n"}, k, leg_a_n, ~leg_a);
    end
  endtask

  task automatic t_reset();
    en = 1'b1;
    period_cmd = 8'd6;
    phase_cmd = 8'd4;
    repeat (3) @(negedge clk);
    check("R1 reset leg_a", 0, leg_a, 1'b0);
    check("R1 reset leg_a_n", 0, leg_a_n, 1'b0);
    check("R1 reset leg_b", 0, leg_b, 1'b0);
    check("R1 reset leg_b_n", 0, leg_b_n, 1'b0);
    rst_n = 1'b1;
    en = 1'b0;
  endtask

  task automatic t_basic();
    run_pattern(10, 7, 35, "basic");
    run_pattern(7, 5, 30, "odd");
  endtask

  task automatic t_zero_shift();
    run_pattern(8, 8, 24, "R6");
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      check("R6 leg_b equals leg_a", k, leg_b, leg_a);
    end
  endtask

  task automatic t_antiphase();
    run_pattern(12, 6, 24, "R7");
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      check("R7 leg_b inverse of leg_a", k, leg_b, ~leg_a);
    end
  endtask

  task automatic t_wrap();
    run_pattern(9, 4, 36, "R10");
  endtask

  task automatic t_clamp();
    run_pattern(1, 0, 12, "R9 min period");
    run_pattern(10, 12, 30, "R9 phase high");
    run_pattern(10, 2, 30, "R9 phase low");
  endtask

  task automatic t_latch();
    stop_run();
    period_cmd = 8'd10;
    phase_cmd = 8'd8;
    en = 1'b1;
    for (int k = 0; k < 30; k++) begin
      bit ea, eb;
      @(negedge clk);
      if (k < 10) begin
        ea = exp_a(k, 10);
        eb = exp_b(k, 10, 8);
      end else begin
        ea = exp_a(k - 10, 6);
        eb = exp_b(k - 10, 6, 4);
      end
      check("R8 leg_a after mid-period change", k, leg_a, ea);
      check("R8 leg_b after mid-period change", k, leg_b, eb);
      if (k == 2) begin
        period_cmd = 8'd6;
        phase_cmd = 8'd4;
      end
    end
  endtask

  task automatic t_disable();
    run_pattern(6, 5, 4, "R1 pre");
    en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R1 disabled leg_a", k, leg_a, 1'b0);
      check("R1 disabled leg_a_n", k, leg_a_n, 1'b0);
      check("R1 disabled leg_b", k, leg_b, 1'b0);
      check("R1 disabled leg_b_n", k, leg_b_n, 1'b0);
    end
    run_pattern(6, 5, 18, "R2 restart");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_zero_shift();
    t_antiphase();
    t_wrap();
    t_clamp();
    t_latch();
    t_disable();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule